// File: doc/BRIEF.md
# Step Attenuator Control Core

This block produces the 6-bit control word for a binary-weighted step attenuator. The bit weights, from MSB to LSB, are 16, 8, 4, 2, 1 and 0.5 dB, so the word covers 0 to 31.5 dB in half-dB steps. An all-zero word selects the minimum-loss state. A mode pin chooses where the word comes from. In parallel mode it comes from six parallel pins. In serial mode it comes from a shift register that is loaded over a data/clock pair. A latch-enable pin opens or closes a level-sensitive hold stage in front of the output, in both modes.

The block runs on a free-running sampling clock. The serial clock, serial data and latch enable are passed through two-flop synchronizers, and serial edges are found on the synchronized copies. A synchronous power-on pulse loads a defined starting word and clears the shift register. The starting word depends on the mode and latch-enable pins at that moment: in some cases it is the parallel word, in the others it comes from a four-entry table indexed by two preset-select pins.

Top module: `step_atten_ctrl`

## Requirements
- R1: With `ser_mode`=1 during `por`, `atten_word` equals `par_word` on the first clock after the pulse, whatever the level of `lat_en`.
- R2: With `ser_mode`=0 and `lat_en`=0 during `por`, `atten_word` is taken from `pu_sel` (bit 1 is the 16 dB select, bit 0 is the 8 dB select): 00 gives 000000, 01 gives 010000, 10 gives 100000, and 11 gives 111110 (31 dB).
- R3: With `ser_mode`=0 and `lat_en`=1 during `por`, `atten_word` equals `par_word` and `pu_sel` has no effect.
- R4: `por` clears the shift register. When the hold stage is later opened in serial mode without any serial clock, the output reads 000000.
- R5: In parallel mode with `lat_en` high, `atten_word` follows `par_word` within three clock cycles of a change.
- R6: In parallel mode with `lat_en` low, `atten_word` holds its value while `par_word` changes. A high-then-low pulse on `lat_en` leaves the output at the `par_word` value present during the pulse.
- R7: Each rising edge of `sclk` shifts `sdata` into a 6-bit register, MSB first. The first bit shifted in ends up at bit 5. Shifting happens at either level of `lat_en`, and while `lat_en` is low the shifting does not change `atten_word`.
- R8: In serial mode the output follows the shift register while `lat_en` is high. After `lat_en` falls, the output keeps its last value even if more bits are shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| por | input | 1 | Synchronous power-on pulse, active high |
| ser_mode | input | 1 | 0 selects the parallel source, 1 selects the serial source |
| lat_en | input | 1 | Hold-stage enable: high is transparent, low holds |
| par_word | input | 6 | Parallel control word, MSB = 16 dB |
| sdata | input | 1 | Serial data, MSB first |
| sclk | input | 1 | Serial shift clock, sampled on its rising edge |
| pu_sel | input | 2 | Preset select; bit 1 is the 16 dB select, bit 0 is the 8 dB select |
| atten_word | output | 6 | Word driving the attenuator stages |

## Verification
The power-up preset is checked with a table that covers every combination of mode and latch enable, and all four `pu_sel` codes. In each row `par_word` is set to a value that differs from the table entry, so a wrong source shows up as a visibly different word. Directed sequences then cover the following:
- a serial load made with the latch closed, then opened, then closed again while more bits are shifted in, which separates transparent behaviour from held behaviour;
- an asymmetric serial pattern, which exposes a wrong shift order;
- parallel changes made during a latch-enable pulse and after it, which separate direct operation from latched operation.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int WORD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              ser_mode,
  input  logic              lat_en,
  input  logic [WORD_W-1:0] par_word,
  input  logic              sdata,
  input  logic              sclk,
  input  logic [1:0]        pu_sel,
  output logic [WORD_W-1:0] atten_word
);

  localparam logic [WORD_W-1:0] PRE_ZERO = '0;
  localparam logic [WORD_W-1:0] PRE_MID  = WORD_W'(1) << (WORD_W - 2);
  localparam logic [WORD_W-1:0] PRE_TOP  = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] PRE_MAX  = ~WORD_W'(1);
  localparam int                LAST     = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] le_pipe, ck_pipe, dt_pipe;
  logic                   ck_prev;
  logic [WORD_W-1:0]      shift_q;
  logic [WORD_W-1:0]      preset;
  logic                   le_sync, sclk_rise;

  assign le_sync   = le_pipe[LAST];
  assign sclk_rise = ck_pipe[LAST] & ~ck_prev;

  always_comb begin
    if (ser_mode || lat_en) preset = par_word;
    else begin
      unique case (pu_sel)
        2'b00:   preset = PRE_ZERO;
        2'b01:   preset = PRE_MID;
        2'b10:   preset = PRE_TOP;
        default: preset = PRE_MAX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      le_pipe <= '0;
      ck_pipe <= '0;
      dt_pipe <= '0;
      ck_prev <= 1'b0;
    end else begin
      le_pipe <= {le_pipe[LAST-1:0], lat_en};
      ck_pipe <= {ck_pipe[LAST-1:0], sclk};
      dt_pipe <= {dt_pipe[LAST-1:0], sdata};
      ck_prev <= ck_pipe[LAST];
    end
  end

  always_ff @(posedge clk) begin
    if (por)            shift_q <= '0;
    else if (sclk_rise) shift_q <= {shift_q[WORD_W-2:0], dt_pipe[LAST]};
  end

  always_ff @(posedge clk) begin
    if (por)          atten_word <= preset;
    else if (le_sync) atten_word <= ser_mode ? shift_q : par_word;
  end

endmodule

module step_atten_ctrl_chk #(
  parameter int WORD_W = 6
) (
  input logic              clk,
  input logic              por,
  input logic              ser_mode,
  input logic              lat_en,
  input logic [WORD_W-1:0] par_word,
  input logic [1:0]        pu_sel,
  input logic              le_sync,
  input logic [WORD_W-1:0] shift_q,
  input logic [WORD_W-1:0] atten_word
);

  p_serial_preset_r1: assert property (@(posedge clk)
    (por && ser_mode) |=> (atten_word == $past(par_word)));

  p_max_preset_r2: assert property (@(posedge clk)
    (por && !ser_mode && !lat_en && pu_sel == 2'b11) |=> (atten_word == {{(WORD_W-1){1'b1}}, 1'b0}));

  p_shift_clear_r4: assert property (@(posedge clk)
    por |=> (shift_q == '0));

  p_direct_follow_r5: assert property (@(posedge clk) disable iff (por)
    (le_sync && !ser_mode) |=> (atten_word == $past(par_word)));

  p_closed_hold_r6: assert property (@(posedge clk) disable iff (por)
    !le_sync |=> $stable(atten_word));

  p_serial_open_r8: assert property (@(posedge clk) disable iff (por)
    (le_sync && ser_mode) |=> (atten_word == $past(shift_q)));

endmodule

bind step_atten_ctrl step_atten_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .por(por), .ser_mode(ser_mode), .lat_en(lat_en),
  .par_word(par_word), .pu_sel(pu_sel), .le_sync(le_sync),
  .shift_q(shift_q), .atten_word(atten_word)
);

// File: tb/tb_step_atten_ctrl.sv
`timescale 1ns/1ps
module tb_step_atten_ctrl;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ser_mode = 1'b0;
  logic       lat_en = 1'b0;
  logic [5:0] par_word = '0;
  logic       sdata = 1'b0;
  logic       sclk = 1'b0;
  logic [1:0] pu_sel = '0;
  logic [5:0] atten_word;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  step_atten_ctrl dut (
    .clk(clk), .por(por), .ser_mode(ser_mode), .lat_en(lat_en),
    .par_word(par_word), .sdata(sdata), .sclk(sclk), .pu_sel(pu_sel),
    .atten_word(atten_word)
  );

  // {ser_mode, lat_en, pu_sel[1:0], par_word[5:0], expected[5:0]}
  localparam logic [15:0] PU_VEC [8] = '{
    {1'b1, 1'b0, 2'b11, 6'b101101, 6'b101101},
    {1'b1, 1'b1, 2'b00, 6'b010011, 6'b010011},
    {1'b0, 1'b0, 2'b00, 6'b111111, 6'b000000},
    {1'b0, 1'b0, 2'b01, 6'b000001, 6'b010000},
    {1'b0, 1'b0, 2'b10, 6'b011111, 6'b100000},
    {1'b0, 1'b0, 2'b11, 6'b000001, 6'b111110},
    {1'b0, 1'b1, 2'b11, 6'b001011, 6'b001011},
    {1'b0, 1'b1, 2'b00, 6'b110001, 6'b110001}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    applied++;
    if (atten_word !== exp) begin
      fails++;
      $display("FAIL %s: atten_word=%b expected=%b at %0t", req, atten_word, exp, $time);
    end
  endtask

  task automatic pulse_por();
    por = 1'b1;
    tick(1);
    por = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    sclk = 1'b0;
    tick(4);
    sclk = 1'b1;
    tick(4);
    sclk = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      applied++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = PU_VEC[i];
      ser_mode = v[15];
      lat_en   = v[14];
      pu_sel   = v[13:12];
      par_word = v[11:6];
      pulse_por();
      check(v[15] ? "R1" : (v[14] ? "R3" : "R2"), v[5:0]);
    end

    // R4: preset from parallel pins, then opening the hold stage exposes a cleared shift register
    ser_mode = 1'b1; lat_en = 1'b0; par_word = 6'b111111;
    pulse_por();
    check("R1", 6'b111111);
    lat_en = 1'b1;
    tick(5);
    check("R4", 6'b000000);

    // R7: load a pattern while closed, output must not move
    lat_en = 1'b0;
    tick(5);
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0);
    tick(4);
    check("R7", 6'b000000);
    lat_en = 1'b1;
    tick(5);
    check("R7", 6'b100110);

    // R8: transparent while open, held after close
    shift_bit(1'b1);
    tick(5);
    check("R8", 6'b001101);
    lat_en = 1'b0;
    tick(5);
    shift_bit(1'b0);
    shift_bit(1'b0);
    tick(5);
    check("R8", 6'b001101);

    // R5: parallel direct operation
    ser_mode = 1'b0; lat_en = 1'b1; par_word = 6'b011010;
    tick(3);
    check("R5", 6'b011010);
    par_word = 6'b000101;
    tick(3);
    check("R5", 6'b000101);

    // R6: parallel latched operation
    lat_en = 1'b0;
    tick(5);
    par_word = 6'b111000;
    tick(6);
    check("R6", 6'b000101);
    par_word = 6'b101010;
    tick(2);
    lat_en = 1'b1;
    tick(5);
    lat_en = 1'b0;
    tick(4);
    par_word = 6'b010101;
    tick(6);
    check("R6", 6'b101010);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule